// File: doc/BRIEF.md
# Charge Status LED Blink Generator

This block drives one open-drain status indicator for a single battery cell. It takes the cell's charge status and a display-mode selection, and it produces a pull-low enable. When the enable is high, the external driver pulls the pin low. When the enable is low, the pin floats. The output never drives the pin high.

Each combination of display mode and status maps to one of five shapes: released, steady low, slow blink, medium blink or fast blink. All blink intervals are whole numbers of periods of a fixed-rate tick input. When the status or the mode changes, the blink phase restarts, so a new pattern always opens with its low interval. The block does not resolve the three-level select pin; that is done outside, and the result arrives here already encoded on `mode_i`.

Top module: `led_blink_gen`

## Requirements
- R1: While `rst_ni` is low, and after its release with inputs at zero, `led_pull_o` is 0.
- R2: With `status_i` = 0 (no battery), `led_pull_o` is 0 in every display mode.
- R3: With `mode_i` = 0, the output behaves as follows:
  - `status_i` = 1 (charging): steady 1.
  - `status_i` = 2 (maintenance): repeats 5 ticks at 1, then 1 tick at 0.
  - `status_i` = 3 (fault): repeats 3 ticks at 1, then 3 ticks at 0.
- R4: With `mode_i` = 1, the output behaves as follows:
  - Charging: steady 1.
  - Maintenance: steady 0.
  - Fault: alternates 1 tick at 1 and 1 tick at 0.
- R5: With `mode_i` = 2, the output behaves as follows:
  - Charging: repeats 5 ticks at 1, then 1 tick at 0.
  - Maintenance: steady 1.
  - Fault: alternates 1 tick at 1 and 1 tick at 0.
- R6: With `mode_i` = 3 (reserved), `led_pull_o` is 0 for every status.
- R7: When `status_i` or `mode_i` changes, the new pattern appears on `led_pull_o` in the next cycle. Its low interval starts from a zero count.
- R8: A tick in the same cycle as a change of `status_i` or `mode_i` is not counted toward the new pattern.
- R9: Blink phases advance only on cycles with `tick_i` = 1. Without ticks, `led_pull_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle pulse per blink time unit |
| status_i | input | 2 | Cell status: 0 no battery, 1 charging, 2 maintenance, 3 fault |
| mode_i | input | 2 | Display mode: 0 select low, 1 select open, 2 select high, 3 reserved |
| led_pull_o | output | 1 | 1 = pull indicator low, 0 = release |

## Verification
A tick and a change of status or mode can land in the same cycle. The restart must then win, and the tick must be dropped. The bench provokes this in a directed case and also lets it occur freely under random stimulus with frequent ticks. It judges the result by counting the ticks until the first release: for a five-tick low interval, the output must stay low through four more ticks and release only on the fifth.

// File: rtl/led_blink_pkg.sv
package led_blink_pkg;
  typedef enum logic [1:0] {
    ST_NONE  = 2'd0,
    ST_CHG   = 2'd1,
    ST_MAINT = 2'd2,
    ST_FAULT = 2'd3
  } status_e;

  typedef enum logic [1:0] {
    DM_LOW  = 2'd0,
    DM_OPEN = 2'd1,
    DM_HIGH = 2'd2,
    DM_RSVD = 2'd3
  } mode_e;

  typedef enum logic [2:0] {
    SHP_OFF  = 3'd0,
    SHP_ON   = 3'd1,
    SHP_SLOW = 3'd2,
    SHP_MID  = 3'd3,
    SHP_FAST = 3'd4
  } shape_e;
endpackage

// File: rtl/led_pattern_dec.sv
module led_pattern_dec
  import led_blink_pkg::*;
(
  input  mode_e   mode_i,
  input  status_e status_i,
  output shape_e  shape_o
);
  always_comb begin
    shape_o = SHP_OFF;
    if (status_i != ST_NONE) begin
      unique case (mode_i)
        DM_LOW: begin
          unique case (status_i)
            ST_CHG:   shape_o = SHP_ON;
            ST_MAINT: shape_o = SHP_SLOW;
            default:  shape_o = SHP_MID;
          endcase
        end
        DM_OPEN: begin
          unique case (status_i)
            ST_CHG:   shape_o = SHP_ON;
            ST_MAINT: shape_o = SHP_OFF;
            default:  shape_o = SHP_FAST;
          endcase
        end
        DM_HIGH: begin
          unique case (status_i)
            ST_CHG:   shape_o = SHP_SLOW;
            ST_MAINT: shape_o = SHP_ON;
            default:  shape_o = SHP_FAST;
          endcase
        end
        default: shape_o = SHP_OFF;
      endcase
    end
  end
endmodule

// File: rtl/led_phase_ctr.sv
module led_phase_ctr
  import led_blink_pkg::*;
#(
  parameter int SHORT_TICKS = 1,
  parameter int MID_TICKS   = 3,
  parameter int LONG_TICKS  = 5
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   tick_i,
  input  logic   restart_i,
  input  shape_e shape_i,
  output logic   low_phase_o
);
  localparam int MAX_TICKS = (LONG_TICKS > MID_TICKS) ? LONG_TICKS : MID_TICKS;
  localparam int CNT_W     = $clog2(MAX_TICKS + 1);

  logic [CNT_W-1:0] cnt_q, low_len, high_len, phase_len;
  logic             low_q;

  always_comb begin
    unique case (shape_i)
      SHP_SLOW: begin low_len = CNT_W'(LONG_TICKS);  high_len = CNT_W'(SHORT_TICKS); end
      SHP_MID:  begin low_len = CNT_W'(MID_TICKS);   high_len = CNT_W'(MID_TICKS);   end
      SHP_FAST: begin low_len = CNT_W'(SHORT_TICKS); high_len = CNT_W'(SHORT_TICKS); end
      default:  begin low_len = CNT_W'(1);           high_len = CNT_W'(1);           end
    endcase
    phase_len = low_q ? low_len : high_len;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      low_q <= 1'b1;
    end else if (restart_i) begin
      cnt_q <= '0;
      low_q <= 1'b1;
    end else if (tick_i) begin
      if (cnt_q >= phase_len - CNT_W'(1)) begin
        cnt_q <= '0;
        low_q <= ~low_q;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign low_phase_o = low_q;

  // R9
  hold_without_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !restart_i) |=> ($stable(low_q) && $stable(cnt_q)));

  // R7
  restart_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (low_q && cnt_q == '0));

  // R3 R5
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CNT_W'(MAX_TICKS));
endmodule

// File: rtl/led_blink_gen.sv
module led_blink_gen
  import led_blink_pkg::*;
#(
  parameter int SHORT_TICKS = 1,
  parameter int MID_TICKS   = 3,
  parameter int LONG_TICKS  = 5
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic [1:0] status_i,
  input  logic [1:0] mode_i,
  output logic       led_pull_o
);
  logic [1:0] status_q, mode_q;
  logic       restart, low_phase;
  shape_e     shape;

  assign restart = (status_i != status_q) || (mode_i != mode_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= 2'd0;
      mode_q   <= 2'd0;
    end else begin
      status_q <= status_i;
      mode_q   <= mode_i;
    end
  end

  led_pattern_dec u_dec (
    .mode_i   (mode_e'(mode_q)),
    .status_i (status_e'(status_q)),
    .shape_o  (shape)
  );

  led_phase_ctr #(
    .SHORT_TICKS (SHORT_TICKS),
    .MID_TICKS   (MID_TICKS),
    .LONG_TICKS  (LONG_TICKS)
  ) u_ctr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick_i),
    .restart_i   (restart),
    .shape_i     (shape),
    .low_phase_o (low_phase)
  );

  always_comb begin
    unique case (shape)
      SHP_OFF: led_pull_o = 1'b0;
      SHP_ON:  led_pull_o = 1'b1;
      default: led_pull_o = low_phase;
    endcase
  end

  // R2
  no_battery_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_i == 2'd0) |=> !led_pull_o);

  // R6
  rsvd_mode_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd3) |=> !led_pull_o);

  // R3 R4
  charge_steady_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_i == 2'd1 && mode_i != 2'd2 && mode_i != 2'd3) |=> led_pull_o);

  // R4
  open_maint_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd1 && status_i == 2'd2) |=> !led_pull_o);

  // R7
  fault_starts_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (restart && status_i == 2'd3 && mode_i != 2'd3) |=> led_pull_o);
endmodule

// File: tb/led_blink_gen_tb.sv
module led_blink_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [1:0] status = 2'd0;
  logic [1:0] mode = 2'd0;
  logic       led;

  int n_run = 0;
  int n_fail = 0;
  bit model_on = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  led_blink_gen dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .tick_i     (tick),
    .status_i   (status),
    .mode_i     (mode),
    .led_pull_o (led)
  );

  // reference: shape lengths from the requirements (0 = steady release, -1 = steady low)
  function automatic int low_ticks(input logic [1:0] m, input logic [1:0] s);
    if (s == 2'd0 || m == 2'd3) return 0;
    case (m)
      2'd0: return (s == 2'd1) ? -1 : (s == 2'd2) ? 5 : 3;
      2'd1: return (s == 2'd1) ? -1 : (s == 2'd2) ? 0 : 1;
      default: return (s == 2'd1) ? 5 : (s == 2'd2) ? -1 : 1;
    endcase
  endfunction

  function automatic int high_ticks(input logic [1:0] m, input logic [1:0] s);
    if (m == 2'd0 && s == 2'd3) return 3;
    return 1;
  endfunction

  function automatic string req_of(input logic [1:0] m, input logic [1:0] s);
    if (m == 2'd3) return "R6";
    if (s == 2'd0) return "R2";
    if (m == 2'd0) return "R3";
    if (m == 2'd1) return "R4";
    return "R5";
  endfunction

  logic [1:0] r_m, r_s;
  bit         r_low;
  int         r_cnt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_m <= 2'd0; r_s <= 2'd0; r_low <= 1'b1; r_cnt <= 0;
    end else if (mode != r_m || status != r_s) begin
      r_m <= mode; r_s <= status; r_low <= 1'b1; r_cnt <= 0;
    end else if (tick) begin
      int len;
      len = r_low ? low_ticks(r_m, r_s) : high_ticks(r_m, r_s);
      if (len < 1) len = 1;
      if (r_cnt + 1 >= len) begin r_cnt <= 0; r_low <= ~r_low; end
      else r_cnt <= r_cnt + 1;
    end
  end

  function automatic bit exp_led(input logic [1:0] m, input logic [1:0] s, input bit lo);
    int l;
    l = low_ticks(m, s);
    if (l == 0) return 1'b0;
    if (l < 0) return 1'b1;
    return lo;
  endfunction

  always @(negedge clk) begin
    if (model_on && rst_n) begin
      bit e;
      e = exp_led(r_m, r_s, r_low);
      n_run++;
      if (led !== e) begin
        n_fail++;
        $display("FAIL %s model m=%0d s=%0d led=%0b exp=%0b", req_of(r_m, r_s), r_m, r_s, led, e);
      end
    end
  end

  task automatic chk(input string req, input bit exp);
    #1;
    n_run++;
    if (led !== exp) begin
      n_fail++;
      $display("FAIL %s directed led=%0b exp=%0b at %0t", req, led, exp, $time);
    end
  endtask

  task automatic set_sel(input logic [1:0] m, input logic [1:0] s, input bit with_tick);
    @(negedge clk);
    mode = m; status = s; tick = with_tick;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1ed0));
    repeat (3) @(negedge clk);
    chk("R1", 1'b0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", 1'b0);
    model_on = 1'b1;

    // R4 charging steady
    set_sel(2'd1, 2'd1, 1'b0);
    chk("R4", 1'b1);
    ticks(7);
    chk("R4", 1'b1);

    // R8 tick coincides with change; R3 maintenance 5 low / 1 released
    set_sel(2'd0, 2'd2, 1'b1);
    chk("R8", 1'b1);
    ticks(4);
    chk("R8", 1'b1);
    ticks(1);
    chk("R3", 1'b0);
    ticks(1);
    chk("R3", 1'b1);

    // R3 fault 3/3, then R7 mid-release change restarts low
    set_sel(2'd0, 2'd3, 1'b0);
    chk("R3", 1'b1);
    ticks(3);
    chk("R3", 1'b0);
    ticks(2);
    chk("R3", 1'b0);
    set_sel(2'd2, 2'd3, 1'b0);
    chk("R7", 1'b1);
    ticks(1);
    chk("R5", 1'b0);
    repeat (20) @(negedge clk);
    chk("R9", 1'b0);
    ticks(1);
    chk("R5", 1'b1);

    // R5 charging slow, maintenance steady
    set_sel(2'd2, 2'd1, 1'b0);
    ticks(5);
    chk("R5", 1'b0);
    set_sel(2'd2, 2'd2, 1'b0);
    ticks(3);
    chk("R5", 1'b1);

    // R4 maintenance released
    set_sel(2'd1, 2'd2, 1'b0);
    chk("R4", 1'b0);

    // R2 no battery, R6 reserved mode
    for (int m = 0; m < 4; m++) begin
      set_sel(m[1:0], 2'd0, 1'b0);
      chk("R2", 1'b0);
    end
    for (int s = 1; s < 4; s++) begin
      set_sel(2'd3, s[1:0], 1'b0);
      ticks(2);
      chk("R6", 1'b0);
    end

    // random mix, checked each cycle by the model
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      tick = ($urandom_range(3) == 0);
      if ($urandom_range(39) == 0) begin
        mode   = 2'($urandom_range(3));
        status = 2'($urandom_range(3));
      end
    end
    @(negedge clk);
    tick = 1'b0;
    @(negedge clk);
    model_on = 1'b0;
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule